// File: doc/BRIEF.md
# Fan Tachometer Revolution Timer

This block measures how fast a fan turns by timing one full revolution of its tachometer signal against a slow reference tick. A fan of the assumed kind gives two tachometer pulses per revolution. The block therefore counts reference ticks from one rising tachometer edge to the second rising edge after it. The result is an 8-bit number that grows as the fan slows down. A stalled fan, or one too slow to measure, reads as full scale (255).

The reference tick is made by an integer divide of the system clock. A 2-bit divisor setting then stretches that tick by 1, 2, 4 or 8. At its own nominal speed, each fan class (fast to slow in four halving steps) gives a count near 153. Each finished measurement loads the output register in a single cycle and raises a one-cycle strobe. Between strobes the previous result stays on the output. Clearing the enable stops the measurement and keeps the last result.

Top module: `fan_period_meter`

## Requirements
- R1: While reset is active, and until the first result after reset, `count_q` reads 255 and `count_vld` is 0.
- R2: `tach_in` passes through a two-flop synchroniser. Only low-to-high transitions count as pulses, so the high and low widths of a pulse do not affect the result; only the spacing of rising edges does.
- R3: The reference tick period is `REF_DIV * 2^div_sel` system clocks (div_sel 0 gives ×1, 1 gives ×2, 2 gives ×4, 3 gives ×8). The tick runs freely from reset and follows a change of `div_sel` at once.
- R4: A published result is the number of reference ticks strictly between a starting rising edge and the second rising edge after it. The closing edge of one revolution is also the starting edge of the next, so back-to-back results need no idle pulses.
- R5: A tachometer whose rising edges are spaced 153/2 tick periods apart (the nominal speed for the selected divisor) reads 153, within ±1 for phase.
- R6: When the running count is at 255 and one more tick arrives before a revolution completes, the block publishes 255 and rearms. A tachometer that never toggles therefore reads 255 again every 256 ticks.
- R7: `count_q` changes only in the cycle where `count_vld` is 1. `count_vld` is never high in two consecutive cycles.
- R8: While `meas_en` is 0, the running count is cleared, no result is published and `count_q` keeps its last value.
- R9: After reset, after re-enabling, or after a saturated result, the first rising edge only starts a measurement and publishes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tach_in | input | 1 | Asynchronous tachometer pulse input |
| meas_en | input | 1 | Measurement enable |
| div_sel | input | 2 | Reference prescale select, ×2^div_sel |
| count_q | output | 8 | Last revolution count (255 means stalled or too slow) |
| count_vld | output | 1 | One-cycle strobe when `count_q` is loaded |

## Verification
The hardest cases to reach from the ports are the cycles where a rising edge and a reference tick arrive together, and the moment a saturated count meets the closing edge of a revolution. Both depend on the exact phase between the free-running prescaler and the tachometer. The stimulus sweeps tachometer periods across all four divisor settings and uses odd pulse widths, so those phases come up many times. A cycle-accurate behavioural model then judges every cycle. A stalled period lets the count reach full scale on its own. The enable is also dropped in the middle of a revolution while the tachometer keeps toggling.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  // Width of the published count and its full-scale value
  localparam int unsigned CNT_W   = 8;
  localparam logic [CNT_W-1:0] CNT_FULL = {CNT_W{1'b1}};

  // Number of divisor settings, selected by a 2-bit field
  localparam int unsigned DIV_SEL_W = 2;
  localparam int unsigned DIV_STEPS = 1 << DIV_SEL_W;

  // Revolution timer state
  typedef enum logic {
    RC_ARMED = 1'b0,  // waiting for a starting edge (counts toward saturation)
    RC_RUN   = 1'b1   // between a starting edge and its closing edge
  } rc_state_e;

  typedef logic [CNT_W-1:0] cnt_t;

  // Number of pulse-spacing intervals in one revolution
  localparam int unsigned EDGES_PER_REV = 2;

endpackage

// File: rtl/fpm_sync.sv
module fpm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              last_q;

  // Next-state of the synchroniser chain
  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign chain_d[g] = async_i;
      end else begin : g_next
        assign chain_d[g] = chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      last_q  <= chain_q[STAGES-1];
    end
  end

  // Low-to-high transition of the synchronised level
  assign rise_o = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/fpm_refgen.sv
module fpm_refgen
  import fpm_pkg::*;
#(
  parameter int unsigned REF_DIV = 1111
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  output logic                 tick_o
);

  localparam int unsigned BASE_W = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
  localparam int unsigned PRE_W  = (DIV_STEPS > 1) ? DIV_STEPS - 1 : 1;
  localparam logic [BASE_W-1:0] BASE_LAST = BASE_W'(REF_DIV - 1);

  logic [BASE_W-1:0]    base_q, base_d;
  logic [PRE_W-1:0]     pre_q,  pre_d;
  logic                 base_tick;
  logic [DIV_STEPS-1:0] tick_cand;

  assign base_tick = (base_q == BASE_LAST);

  // Base divider and free-running prescale counter
  always_comb begin
    base_d = base_q;
    pre_d  = pre_q;
    if (base_tick) begin
      base_d = '0;
      pre_d  = pre_q + PRE_W'(1);
    end else begin
      base_d = base_q + BASE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      pre_q  <= '0;
    end else begin
      base_q <= base_d;
      pre_q  <= pre_d;
    end
  end

  // One tick candidate per divisor setting: setting k passes one base tick in 2^k
  generate
    for (genvar k = 0; k < DIV_STEPS; k++) begin : g_div
      if (k == 0) begin : g_unity
        assign tick_cand[k] = base_tick;
      end else begin : g_scaled
        localparam logic [PRE_W-1:0] MASK = PRE_W'((1 << k) - 1);
        assign tick_cand[k] = base_tick && ((pre_q & MASK) == MASK);
      end
    end
  endgenerate

  assign tick_o = tick_cand[div_sel_i];

endmodule

// File: rtl/fpm_revcnt.sv
module fpm_revcnt
  import fpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      rise_i,
  input  logic      tick_i,
  output cnt_t      value_o,
  output logic      value_vld_o,
  output rc_state_e state_o,
  output cnt_t      run_cnt_o
);

  localparam int unsigned EDGE_W = $clog2(EDGES_PER_REV);
  localparam logic [EDGE_W-1:0] EDGE_LAST = EDGE_W'(EDGES_PER_REV - 1);

  rc_state_e         state_q, state_d;
  cnt_t              cnt_q,   cnt_d;
  logic [EDGE_W-1:0] edge_q,  edge_d;
  cnt_t              val_q,   val_d;
  logic              vld_q,   vld_d;
  logic              val_en;

  logic rev_done;
  logic saturate;

  assign rev_done = rise_i && (state_q == RC_RUN) && (edge_q == EDGE_LAST);
  assign saturate = tick_i && (cnt_q == CNT_FULL);

  // Next-state logic, highest priority first
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    edge_d  = edge_q;
    val_d   = val_q;
    val_en  = 1'b0;
    vld_d   = 1'b0;
    if (!en_i) begin
      state_d = RC_ARMED;
      cnt_d   = '0;
      edge_d  = '0;
    end else if (rev_done) begin
      val_d   = cnt_q;
      val_en  = 1'b1;
      vld_d   = 1'b1;
      cnt_d   = '0;
      edge_d  = '0;
    end else if (saturate) begin
      val_d   = CNT_FULL;
      val_en  = 1'b1;
      vld_d   = 1'b1;
      cnt_d   = '0;
      edge_d  = '0;
      state_d = RC_ARMED;
    end else if (rise_i && (state_q == RC_ARMED)) begin
      state_d = RC_RUN;
      cnt_d   = '0;
      edge_d  = '0;
    end else begin
      if (rise_i) begin
        edge_d = edge_q + EDGE_W'(1);
      end
      if (tick_i) begin
        cnt_d = cnt_q + cnt_t'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RC_ARMED;
      cnt_q   <= '0;
      edge_q  <= '0;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      edge_q  <= edge_d;
      vld_q   <= vld_d;
    end
  end

  // Result register, loaded only at the end of a measurement
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= CNT_FULL;
    end else if (val_en) begin
      val_q <= val_d;
    end
  end

  assign value_o     = val_q;
  assign value_vld_o = vld_q;
  assign state_o     = state_q;
  assign run_cnt_o   = cnt_q;

endmodule

// File: rtl/fan_period_meter.sv
module fan_period_meter
  import fpm_pkg::*;
#(
  parameter int unsigned REF_DIV     = 1111,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tach_in,
  input  logic                 meas_en,
  input  logic [DIV_SEL_W-1:0] div_sel,
  output logic [CNT_W-1:0]     count_q,
  output logic                 count_vld
);

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic      tach_rise;
  logic      ref_tick;
  rc_state_e rc_state;
  cnt_t      rc_cnt;

  fpm_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_ni  (rst_sync_q),
    .async_i (tach_in),
    .rise_o  (tach_rise)
  );

  fpm_refgen #(
    .REF_DIV (REF_DIV)
  ) u_refgen (
    .clk       (clk),
    .rst_ni    (rst_sync_q),
    .div_sel_i (div_sel),
    .tick_o    (ref_tick)
  );

  fpm_revcnt u_revcnt (
    .clk         (clk),
    .rst_ni      (rst_sync_q),
    .en_i        (meas_en),
    .rise_i      (tach_rise),
    .tick_i      (ref_tick),
    .value_o     (count_q),
    .value_vld_o (count_vld),
    .state_o     (rc_state),
    .run_cnt_o   (rc_cnt)
  );

endmodule

// File: rtl/fpm_chk.sv
module fpm_chk
  import fpm_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      tach_in,
  input logic      meas_en,
  input cnt_t      count_q,
  input logic      count_vld,
  input logic      rise,
  input rc_state_e state,
  input cnt_t      run_cnt
);

  // R7: the strobe lasts one cycle
  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    count_vld |=> !count_vld);

  // R7: the result holds between strobes
  a_r7_value_held: assert property (@(posedge clk) disable iff (!rst_n)
    !count_vld |-> $stable(count_q));

  // R8: no result while disabled
  a_r8_no_strobe_off: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_en |=> !count_vld);

  // R8: running count cleared while disabled
  a_r8_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_en |=> (run_cnt == '0));

  // R6: a result published from the armed state is the saturated value
  a_r6_armed_publish_full: assert property (@(posedge clk) disable iff (!rst_n)
    (count_vld && ($past(state) == RC_ARMED)) |-> (count_q == CNT_FULL));

  // R2: a detected edge follows a high input two clocks earlier
  a_r2_rise_from_input: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> $past(tach_in, 2));

endmodule

bind fan_period_meter fpm_chk u_fpm_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tach_in   (tach_in),
  .meas_en   (meas_en),
  .count_q   (count_q),
  .count_vld (count_vld),
  .rise      (tach_rise),
  .state     (rc_state),
  .run_cnt   (rc_cnt)
);

// File: tb/tb_fan_period_meter.sv
module tb_fan_period_meter;

  localparam int REF_DIV = 4;
  localparam int FULL    = 255;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tach_in;
  logic       meas_en;
  logic [1:0] div_sel;
  logic [7:0] count_q;
  logic       count_vld;

  int n_cmp  = 0;
  int n_fail = 0;
  int cyc    = 0;
  string cur_req = "R1";
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  fan_period_meter #(.REF_DIV(REF_DIV), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .meas_en(meas_en),
    .div_sel(div_sel), .count_q(count_q), .count_vld(count_vld)
  );

  // Behavioural reference model
  int  m_val = FULL;
  bit  m_vld = 0;
  int  m_cnt = 0;
  bit  m_run = 0;
  int  m_half = 0;
  int  m_ticks = 0;
  bit  t_hist[$];   // sampled tach levels, newest at back
  bit  m_rst_pipe[$];
  int  last_val = -1;
  int  n_vld = 0;

  task automatic m_clear();
    m_val = FULL; m_vld = 0; m_cnt = 0; m_run = 0; m_half = 0; m_ticks = 0;
    t_hist = '{0, 0, 0};
  endtask

  initial begin
    m_clear();
    m_rst_pipe = '{0, 0};
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rst_pipe = '{0, 0};
      m_clear();
    end else if (!m_rst_pipe[0]) begin
      // internal reset still held this edge
      void'(m_rst_pipe.pop_front());
      m_rst_pipe.push_back(1'b1);
      m_clear();
    end else begin
      bit rise, tick;
      void'(m_rst_pipe.pop_front());
      m_rst_pipe.push_back(1'b1);
      rise = t_hist[1] && !t_hist[0];
      void'(t_hist.pop_front());
      t_hist.push_back(tach_in);
      tick = ((m_ticks + 1) % (REF_DIV << div_sel)) == 0;
      m_ticks++;
      m_vld = 0;
      if (!meas_en) begin
        m_cnt = 0; m_run = 0; m_half = 0;
      end else if (rise && m_run && m_half == 1) begin
        m_val = m_cnt; m_vld = 1; m_cnt = 0; m_half = 0;
      end else if (tick && m_cnt == FULL) begin
        m_val = FULL; m_vld = 1; m_cnt = 0; m_run = 0; m_half = 0;
      end else if (rise && !m_run) begin
        m_run = 1; m_cnt = 0; m_half = 0;
      end else begin
        if (rise) m_half = 1;
        if (tick) m_cnt++;
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      cyc++;
      n_cmp++;
      if (count_q !== 8'(m_val) || count_vld !== m_vld) begin
        n_fail++;
        $display("FAIL %s cycle %0d: count_q=%0d vld=%0b, expected count_q=%0d vld=%0b",
                 cur_req, cyc, count_q, count_vld, m_val, m_vld);
      end
      if (count_vld === 1'b1) begin
        last_val = count_q;
        n_vld++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    n_cmp++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulses(input int hi, input int lo, input int n);
    for (int i = 0; i < n; i++) begin
      tach_in = 1'b1; wait_clk(hi);
      tach_in = 1'b0; wait_clk(lo);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  endtask

  // Watchdog
  initial begin
    wait_clk(150000);
    n_cmp++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    int snap_val, snap_n;
    rst_n = 1'b0; tach_in = 1'b0; meas_en = 1'b0; div_sel = 2'd0;
    wait_clk(3);
    // R1: reset state
    check(count_q == 8'd255, "R1 reset count", count_q, 255);
    check(count_vld == 1'b0, "R1 reset strobe", count_vld, 0);
    rst_n = 1'b1;
    wait_clk(4);

    // R9/R4/R5: nominal speed, divisor x1 (edge spacing 306 clk = 76.5 ticks)
    cur_req = "R9"; meas_en = 1'b1;
    snap_n = n_vld;
    pulses(153, 153, 1);
    check(n_vld == snap_n, "R9 first edge publishes nothing", n_vld - snap_n, 0);
    cur_req = "R5";
    pulses(153, 153, 6);
    check(last_val >= 152 && last_val <= 154, "R5 nominal div x1", last_val, 153);
    check(n_vld - snap_n >= 2, "R4 back-to-back results", n_vld - snap_n, 3);

    // R3/R5: the other three divisor settings at their nominal speeds
    cur_req = "R3";
    for (int d = 1; d < 4; d++) begin
      div_sel = 2'(d);
      pulses(153 << d, 153 << d, 5);
      check(last_val >= 152 && last_val <= 154, "R3 R5 nominal scaled divisor", last_val, 153);
    end

    // R3: slow divisor with a fast fan gives a proportionally smaller count
    div_sel = 2'd3;
    pulses(153, 153, 5);
    check(last_val >= 18 && last_val <= 20, "R3 div x8 at fast speed", last_val, 19);

    // R2: narrow high pulses, same rising-edge spacing
    cur_req = "R2"; div_sel = 2'd0;
    pulses(7, 299, 6);
    check(last_val >= 152 && last_val <= 154, "R2 narrow pulses", last_val, 153);
    pulses(301, 5, 6);
    check(last_val >= 152 && last_val <= 154, "R2 wide pulses", last_val, 153);

    // R4: fast fan, odd spacing to sweep edge/tick phase
    cur_req = "R4";
    pulses(11, 10, 12);
    check(last_val >= 9 && last_val <= 11, "R4 fast fan count", last_val, 10);
    pulses(3, 2, 12);
    check(last_val <= 3, "R4 very fast fan", last_val, 2);

    // R6: stalled fan saturates and repeats
    cur_req = "R6";
    tach_in = 1'b0;
    snap_n = n_vld;
    wait_clk(2200);
    check(last_val == FULL, "R6 stall reads full scale", last_val, FULL);
    check(n_vld - snap_n == 2, "R6 repeats every 256 ticks", n_vld - snap_n, 2);
    // very slow fan: edge spacing past full scale
    pulses(600, 600, 3);
    check(last_val == FULL, "R6 too slow reads full scale", last_val, FULL);

    // R8: disable mid-revolution with the tach still toggling
    cur_req = "R8";
    pulses(153, 153, 4);
    tach_in = 1'b1; wait_clk(100);
    meas_en = 1'b0;
    snap_val = count_q; snap_n = n_vld;
    pulses(20, 20, 20);
    check(n_vld == snap_n, "R8 no strobe while disabled", n_vld - snap_n, 0);
    check(count_q == 8'(snap_val), "R8 value held while disabled", count_q, snap_val);
    wait_clk(2000);
    check(count_q == 8'(snap_val), "R8 no saturation while disabled", count_q, snap_val);

    // R9/R7: re-enable; first edge arms only
    cur_req = "R9"; meas_en = 1'b1;
    pulses(153, 153, 1);
    check(n_vld == snap_n, "R9 arm after re-enable", n_vld - snap_n, 0);
    cur_req = "R7";
    pulses(153, 153, 3);
    check(last_val >= 152 && last_val <= 154, "R7 result after re-enable", last_val, 153);

    // R3: divisor change mid-measurement follows the model
    cur_req = "R3";
    pulses(100, 100, 2);
    div_sel = 2'd2;
    pulses(100, 100, 4);
    check(last_val >= 24 && last_val <= 26, "R3 after divisor change", last_val, 25);

    // R1: reset in mid-run returns to full scale
    cur_req = "R1";
    rst_n = 1'b0; wait_clk(2);
    check(count_q == 8'd255 && count_vld == 1'b0, "R1 reset again", count_q, 255);
    rst_n = 1'b1;
    wait_clk(10);
    finish_run();
  end

endmodule